// File: doc/BRIEF.md
# IP and Transport Header Exception Checker

This block watches a received packet that arrives one byte per beat on a valid/last stream, beginning at the first byte of the network-layer header. It parses an IPv4 header (the twenty-byte form; longer headers are only detected) or the fixed forty-byte IPv6 header, and then the first bytes of a TCP or UDP header. From these bytes it classifies the packet. The input stream is never stalled.

One cycle after the final byte it presents a single status record. The record carries a flag for IPv6, a flag for a TCP or UDP payload, a fragment flag, a network-layer exception flag, a transport-layer error flag, the receive-error flag that arrived with the last byte, and an 8-bit reason code. Network-layer checks are ranked first. Transport checks are applied only to clean, unfragmented IP packets that carry no receive error. Within each class the smallest applicable code is reported. A new packet may start on the cycle in which the previous record is shown.

Top module: `ip_l4_checker`

## Requirements
- R1: `s_ready_o` is always 1. `st_valid_o` is 1 for exactly one cycle, the cycle after each beat with `s_last_i`=1, and is 0 in every other cycle. A packet may begin in that same cycle.
- R2: If the high nibble of byte 0 (the version) is neither 4 nor 6, the record sets the exception flag with code 1. `is_v6` and `tcp_udp` are then 0.
- R3: For version 4, the 16-bit big-endian words over the first IHL*4 bytes (IHL is the low nibble of byte 0) are summed in ones' complement. If the folded sum is not 0xFFFF, the result is code 2.
- R4: If the packet ends before the whole header arrives, the result is code 3. The header is 40 bytes for version 6 and IHL*4 bytes for version 4. An IHL below 5 also gives code 3. Code 3 takes priority over codes 2, 4, 5 and 6.
- R5: If fewer bytes arrive than the IP length, the result is code 4. The IP length is bytes 2-3 for version 4, and 40 plus bytes 4-5 for version 6. Bytes beyond the IP length are allowed and ignored.
- R6: A zero in the IPv4 TTL (byte 8) or the IPv6 hop limit (byte 7) gives code 5. An IPv4 IHL above 5 gives code 6. When several network-layer codes apply, the smallest one is reported.
- R7: The fragment flag is set in two cases. For IPv4, it is set when byte 6 bit 5 (more fragments) is 1 or when the 13-bit offset (byte 6 bits 4:0 and byte 7) is non-zero. For IPv6, it is set when the next header (byte 6) is 44. A fragment never reports a transport error.
- R8: `tcp_udp` is set when the full header has arrived and the protocol is 6 or 17. The protocol is byte 9 for IPv4 and byte 6 for IPv6. Other protocols get no transport checks.
- R9: The transport room is the IP length minus the header length. If the room is below 8 for UDP, or below 20 for TCP, the result is transport code 1.
- R10: If the UDP length (transport bytes 4-5) exceeds the transport room, the result is transport code 3.
- R11: If the source port (transport bytes 0-1) or the destination port (bytes 2-3) is zero, the result is transport code 4.
- R12: The TCP flags are transport byte 13, with FIN at bit 0, SYN at bit 1, RST at bit 2 and URG at bit 5. Bits 5:0 equal to 000001 give code 8. Bits 5:0 all zero give code 9. FIN with RST gives 10. SYN with URG gives 11. SYN with RST gives 12. SYN with FIN gives 13. If several of these apply, the smallest code wins, and codes 1, 3 and 4 rank ahead of all of them.
- R13: `s_rx_err_i`, sampled on the last beat, is reported as `st_rx_err_o`. When it is set, all other flags are 0 and the code is 0.
- R14: The exception flag and the transport error flag are never both set. When neither is set, the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Byte valid |
| s_data_i | input | 8 | Packet byte |
| s_last_i | input | 1 | Final byte of packet |
| s_rx_err_i | input | 1 | Receive error, sampled with the last byte |
| s_ready_o | output | 1 | Always ready |
| st_valid_o | output | 1 | Status record valid |
| st_is_v6_o | output | 1 | Packet is IPv6 |
| st_tcp_udp_o | output | 1 | Protocol is TCP or UDP |
| st_frag_o | output | 1 | Packet is a fragment |
| st_ip_exc_o | output | 1 | Network-layer exception |
| st_l4_err_o | output | 1 | Transport-layer error |
| st_rx_err_o | output | 1 | Receive error reported |
| st_code_o | output | 8 | Reason code |

## Verification
Clean IPv4 UDP, IPv4 TCP, ICMP and IPv6 packets establish that a clean packet yields code 0 with correct flags. Each exception is then triggered alone, at the smallest length and field value that trips it and at the largest that does not: exactly-fitting UDP length, transport room of exactly 8, trailing pad. Pairs of simultaneous faults (bad checksum with zero TTL, zero TTL with options, oversize UDP length with a zero port, three TCP flags at once) show that the ranking follows code order. Fragments carrying a bad port, a receive error on a bad header, and two packets sent with no gap show the suppression rules and the record timing.

// File: rtl/ipchk_pkg.sv
package ipchk_pkg;
  localparam int unsigned LEN_W   = 16;
  localparam int unsigned CNT_W   = LEN_W + 1;
  localparam int unsigned V4_HDR  = 20;
  localparam int unsigned V6_HDR  = 40;
  localparam int unsigned UDP_HDR = 8;
  localparam int unsigned TCP_HDR = 20;

  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;
  localparam logic [7:0] NH_FRAG   = 8'd44;

  // network-layer codes
  localparam logic [7:0] NX_VERSION = 8'd1;
  localparam logic [7:0] NX_CSUM    = 8'd2;
  localparam logic [7:0] NX_HDR_CUT = 8'd3;
  localparam logic [7:0] NX_LEN_CUT = 8'd4;
  localparam logic [7:0] NX_HOP0    = 8'd5;
  localparam logic [7:0] NX_OPTS    = 8'd6;
  // transport codes
  localparam logic [7:0] TX_SHORT   = 8'd1;
  localparam logic [7:0] TX_ULEN    = 8'd3;
  localparam logic [7:0] TX_PORT0   = 8'd4;
  localparam logic [7:0] TX_FIN1    = 8'd8;
  localparam logic [7:0] TX_NOFLAG  = 8'd9;
  localparam logic [7:0] TX_FINRST  = 8'd10;
  localparam logic [7:0] TX_SYNURG  = 8'd11;
  localparam logic [7:0] TX_SYNRST  = 8'd12;
  localparam logic [7:0] TX_SYNFIN  = 8'd13;

  typedef struct packed {
    logic [3:0]       ver;
    logic [3:0]       ihl;
    logic [LEN_W-1:0] len16;
    logic             mf;
    logic [12:0]      frag_off;
    logic [7:0]       hop;
    logic [7:0]       proto;
    logic [LEN_W-1:0] sport;
    logic [LEN_W-1:0] dport;
    logic [LEN_W-1:0] ulen;
    logic [5:0]       tflags;
  } hdr_fields_t;
endpackage

// File: rtl/ipchk_parse.sv
module ipchk_parse
  import ipchk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             last_i,
  input  logic [7:0]       byte_i,
  input  logic             pkt_err_i,
  output logic             first_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o,
  output hdr_fields_t      fld_o,
  output logic             rx_err_o,
  output logic             done_o
);
  logic             in_pkt_q, rx_q, done_q;
  logic [CNT_W-1:0] cnt_q, l4_base, rel;
  hdr_fields_t      fld_q;
  logic             is4, is6, l4_zone;

  assign first_o = !in_pkt_q;
  assign idx_o   = in_pkt_q ? cnt_q : '0;
  assign is4     = fld_q.ver == 4'd4;
  assign is6     = fld_q.ver == 4'd6;
  assign l4_base = is6 ? CNT_W'(V6_HDR) : CNT_W'({fld_q.ihl, 2'b00});
  assign rel     = idx_o - l4_base;
  assign l4_zone = in_pkt_q && (idx_o >= l4_base);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= 1'b0;
      done_q   <= 1'b0;
      fld_q    <= '0;
    end else begin
      done_q <= beat_i && last_i;
      if (beat_i) begin
        in_pkt_q <= !last_i;
        cnt_q    <= (&idx_o) ? idx_o : idx_o + 1'b1;
        if (last_i) rx_q <= pkt_err_i;
        if (first_o) begin
          fld_q.ver <= byte_i[7:4];
          fld_q.ihl <= byte_i[3:0];
        end
        if (!first_o && is4) begin
          case (idx_o)
            CNT_W'(2): fld_q.len16[15:8] <= byte_i;
            CNT_W'(3): fld_q.len16[7:0]  <= byte_i;
            CNT_W'(6): begin
              fld_q.mf             <= byte_i[5];
              fld_q.frag_off[12:8] <= byte_i[4:0];
            end
            CNT_W'(7): fld_q.frag_off[7:0] <= byte_i;
            CNT_W'(8): fld_q.hop   <= byte_i;
            CNT_W'(9): fld_q.proto <= byte_i;
            default: ;
          endcase
        end
        if (!first_o && is6) begin
          case (idx_o)
            CNT_W'(4): fld_q.len16[15:8] <= byte_i;
            CNT_W'(5): fld_q.len16[7:0]  <= byte_i;
            CNT_W'(6): begin
              fld_q.proto <= byte_i;
              fld_q.mf    <= 1'b0;
              fld_q.frag_off <= '0;
            end
            CNT_W'(7): fld_q.hop <= byte_i;
            default: ;
          endcase
        end
        if (l4_zone) begin
          case (rel)
            CNT_W'(0):  fld_q.sport[15:8] <= byte_i;
            CNT_W'(1):  fld_q.sport[7:0]  <= byte_i;
            CNT_W'(2):  fld_q.dport[15:8] <= byte_i;
            CNT_W'(3):  fld_q.dport[7:0]  <= byte_i;
            CNT_W'(4):  fld_q.ulen[15:8]  <= byte_i;
            CNT_W'(5):  fld_q.ulen[7:0]   <= byte_i;
            CNT_W'(13): fld_q.tflags      <= byte_i[5:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign fld_o    = fld_q;
  assign rx_err_o = rx_q;
  assign done_o   = done_q;

  assert_idx_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !last_i && !(&idx_o)) |=> (idx_o == $past(idx_o) + 1'b1));
  assert_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && last_i) |=> first_o);
endmodule

// File: rtl/ipchk_csum.sv
module ipchk_csum
  import ipchk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             first_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [3:0]       ihl_i,
  output logic             ok_o
);
  logic [7:0]  hi_q;
  logic [15:0] acc_q;
  logic [16:0] sum;
  logic        incl;

  assign incl = first_i || (idx_i < CNT_W'({ihl_i, 2'b00}));
  assign sum  = {1'b0, acc_q} + {1'b0, hi_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      acc_q <= '0;
    end else if (beat_i && first_i) begin
      hi_q  <= byte_i;
      acc_q <= '0;
    end else if (beat_i && incl) begin
      if (!idx_i[0]) hi_q <= byte_i;
      else           acc_q <= sum[15:0] + {15'd0, sum[16]};  // end-around carry
    end
  end

  assign ok_o = acc_q == 16'hFFFF;

  assert_acc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && first_i) |=> !ok_o);
endmodule

// File: rtl/ipchk_classify.sv
module ipchk_classify
  import ipchk_pkg::*;
(
  input  hdr_fields_t      fld_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             csum_ok_i,
  input  logic             rx_err_i,
  output logic             is_v6_o,
  output logic             tcp_udp_o,
  output logic             frag_o,
  output logic             ip_exc_o,
  output logic             l4_err_o,
  output logic [7:0]       code_o
);
  logic             is4, is6, is_ip, hdr_full, tcp, udp, tu, frag, run_l4;
  logic [CNT_W-1:0] hdr_len, ip_len, room, need;
  logic [7:0]       ip_code, l4_code;
  logic [5:0]       f;

  always_comb begin
    is4      = fld_i.ver == 4'd4;
    is6      = fld_i.ver == 4'd6;
    is_ip    = is4 || is6;
    hdr_len  = is6 ? CNT_W'(V6_HDR) : CNT_W'({fld_i.ihl, 2'b00});
    ip_len   = is6 ? CNT_W'(V6_HDR) + CNT_W'(fld_i.len16) : CNT_W'(fld_i.len16);
    hdr_full = is6 ? (cnt_i >= hdr_len) : (fld_i.ihl >= 4'd5 && cnt_i >= hdr_len);
    room     = (ip_len > hdr_len) ? ip_len - hdr_len : '0;

    if (!is_ip)                        ip_code = NX_VERSION;
    else if (!hdr_full)                ip_code = NX_HDR_CUT;
    else if (is4 && !csum_ok_i)        ip_code = NX_CSUM;
    else if (cnt_i < ip_len)           ip_code = NX_LEN_CUT;
    else if (fld_i.hop == 8'd0)        ip_code = NX_HOP0;
    else if (is4 && fld_i.ihl != 4'd5) ip_code = NX_OPTS;
    else                               ip_code = 8'd0;

    tcp  = fld_i.proto == PROTO_TCP;
    udp  = fld_i.proto == PROTO_UDP;
    tu   = is_ip && hdr_full && (tcp || udp);
    frag = is_ip && hdr_full &&
           (is4 ? (fld_i.mf || fld_i.frag_off != '0) : (fld_i.proto == NH_FRAG));
    need = tcp ? CNT_W'(TCP_HDR) : CNT_W'(UDP_HDR);
    f    = fld_i.tflags;

    if (room < need)                                         l4_code = TX_SHORT;
    else if (udp && CNT_W'(fld_i.ulen) > room)               l4_code = TX_ULEN;
    else if (fld_i.sport == '0 || fld_i.dport == '0)         l4_code = TX_PORT0;
    else if (tcp && f == 6'b000001)                          l4_code = TX_FIN1;
    else if (tcp && f == 6'b000000)                          l4_code = TX_NOFLAG;
    else if (tcp && f[0] && f[2])                            l4_code = TX_FINRST;
    else if (tcp && f[1] && f[5])                            l4_code = TX_SYNURG;
    else if (tcp && f[1] && f[2])                            l4_code = TX_SYNRST;
    else if (tcp && f[1] && f[0])                            l4_code = TX_SYNFIN;
    else                                                     l4_code = 8'd0;

    run_l4 = tu && (ip_code == 8'd0) && !frag;

    if (rx_err_i) begin
      is_v6_o = 1'b0; tcp_udp_o = 1'b0; frag_o = 1'b0;
      ip_exc_o = 1'b0; l4_err_o = 1'b0; code_o = 8'd0;
    end else begin
      is_v6_o   = is6;
      tcp_udp_o = tu;
      frag_o    = frag;
      ip_exc_o  = ip_code != 8'd0;
      l4_err_o  = run_l4 && (l4_code != 8'd0);
      code_o    = ip_exc_o ? ip_code : (run_l4 ? l4_code : 8'd0);
    end
  end
endmodule

// File: rtl/ip_l4_checker.sv
module ip_l4_checker
  import ipchk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  input  logic       s_rx_err_i,
  output logic       s_ready_o,
  output logic       st_valid_o,
  output logic       st_is_v6_o,
  output logic       st_tcp_udp_o,
  output logic       st_frag_o,
  output logic       st_ip_exc_o,
  output logic       st_l4_err_o,
  output logic       st_rx_err_o,
  output logic [7:0] st_code_o
);
  logic             beat, first, rx_err, done, csum_ok;
  logic             c_v6, c_tu, c_frag, c_exc, c_l4;
  logic [7:0]       c_code;
  logic [CNT_W-1:0] idx, cnt;
  hdr_fields_t      fld;

  assign s_ready_o = 1'b1;
  assign beat      = s_valid_i;

  ipchk_parse u_parse (
    .clk_i, .rst_ni, .beat_i(beat), .last_i(s_last_i), .byte_i(s_data_i),
    .pkt_err_i(s_rx_err_i), .first_o(first), .idx_o(idx), .cnt_o(cnt),
    .fld_o(fld), .rx_err_o(rx_err), .done_o(done)
  );

  ipchk_csum u_csum (
    .clk_i, .rst_ni, .beat_i(beat), .first_i(first), .idx_i(idx),
    .byte_i(s_data_i), .ihl_i(fld.ihl), .ok_o(csum_ok)
  );

  ipchk_classify u_cls (
    .fld_i(fld), .cnt_i(cnt), .csum_ok_i(csum_ok), .rx_err_i(rx_err),
    .is_v6_o(c_v6), .tcp_udp_o(c_tu), .frag_o(c_frag), .ip_exc_o(c_exc),
    .l4_err_o(c_l4), .code_o(c_code)
  );

  assign st_valid_o   = done;
  assign st_is_v6_o   = done && c_v6;
  assign st_tcp_udp_o = done && c_tu;
  assign st_frag_o    = done && c_frag;
  assign st_ip_exc_o  = done && c_exc;
  assign st_l4_err_o  = done && c_l4;
  assign st_rx_err_o  = done && rx_err;
  assign st_code_o    = done ? c_code : 8'd0;

  assert_rec_after_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_last_i) |=> st_valid_o);
  assert_no_rec_midpkt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && !s_last_i) |=> !st_valid_o);
  assert_exc_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ip_exc_o |-> (st_code_o >= 8'd1 && st_code_o <= 8'd6));
  assert_frag_no_l4_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_frag_o |-> !st_l4_err_o);
  assert_l4_needs_tu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_l4_err_o |-> st_tcp_udp_o);
  assert_rx_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rx_err_o |-> (!st_ip_exc_o && !st_l4_err_o && !st_frag_o && st_code_o == 8'd0));
  assert_excl_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_ip_exc_o && st_l4_err_o));
  assert_clean_code_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_ip_exc_o && !st_l4_err_o) |-> st_code_o == 8'd0);
endmodule

// File: tb/ip_l4_checker_test.sv
module ip_l4_checker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, st_valid, st_v6, st_tu, st_frag, st_exc, st_l4, st_rx;
  logic [7:0] st_code;

  int checks = 0, fails = 0;
  logic [7:0]  pk [0:95];
  logic [14:0] snap;
  bit pend = 0;

  always #4 clk = ~clk;

  ip_l4_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_last_i(s_last), .s_rx_err_i(s_err), .s_ready_o(s_ready),
    .st_valid_o(st_valid), .st_is_v6_o(st_v6), .st_tcp_udp_o(st_tu),
    .st_frag_o(st_frag), .st_ip_exc_o(st_exc), .st_l4_err_o(st_l4),
    .st_rx_err_o(st_rx), .st_code_o(st_code)
  );

  function automatic logic [14:0] ex(bit v6, bit tu, bit fr, bit ie, bit le, bit rx, int code);
    return {1'b1, v6, tu, fr, ie, le, rx, 8'(code)};
  endfunction

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 96; i++) pk[i] = 8'd0;
  endtask

  task automatic put16(int off, int v);
    pk[off] = 8'(v >> 8); pk[off+1] = 8'(v);
  endtask

  task automatic fix_csum(int ihl);
    int s = 0;
    pk[10] = 0; pk[11] = 0;
    for (int w = 0; w < ihl * 2; w++) s += {pk[2*w], pk[2*w+1]};
    s = (s & 16'hFFFF) + (s >> 16);
    s = (s & 16'hFFFF) + (s >> 16);
    s = ~s;
    put16(10, s & 16'hFFFF);
  endtask

  task automatic mk4(int ihl, int proto, int tot, int ttl, int b6, int b7);
    clr();
    pk[0] = 8'h40 | 8'(ihl);
    put16(2, tot);
    put16(4, 16'h1234);
    pk[6] = 8'(b6); pk[7] = 8'(b7); pk[8] = 8'(ttl); pk[9] = 8'(proto);
    pk[12] = 8'd10; pk[15] = 8'd1; pk[16] = 8'd10; pk[19] = 8'd2;
    fix_csum(ihl);
  endtask

  task automatic mk6(int pay, int nxt, int hop);
    clr();
    pk[0] = 8'h60;
    put16(4, pay);
    pk[6] = 8'(nxt); pk[7] = 8'(hop);
    pk[8] = 8'hfe; pk[23] = 8'd1; pk[24] = 8'hfe; pk[39] = 8'd2;
  endtask

  task automatic l4(int base, int sp, int dp, int ul, int fl);
    put16(base, sp); put16(base + 2, dp); put16(base + 4, ul);
    pk[base+13] = 8'(fl);
  endtask

  task automatic take();
    snap = {st_valid, st_v6, st_tu, st_frag, st_exc, st_l4, st_rx, st_code};
  endtask

  task automatic send(int n, bit err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0 && pend) take();
      s_valid = 1'b1; s_data = pk[i]; s_last = (i == n - 1); s_err = err && (i == n - 1);
    end
    @(posedge clk);
    pend = 1;
  endtask

  task automatic finish_pkt();
    @(negedge clk);
    take();
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0; pend = 0;
  endtask

  task automatic run(int n, bit err);
    send(n, err); finish_pkt();
  endtask

  task automatic udp4(int tot, int sp, int dp, int ul);
    mk4(5, 17, tot, 64, 0, 0); l4(20, sp, dp, ul, 0);
  endtask

  task automatic tcp4(int tot, int sp, int dp, int fl);
    mk4(5, 6, tot, 64, 0, 0); l4(20, sp, dp, 0, fl);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (s_ready !== 1'b1 || st_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%b%b expected=10", s_ready, st_valid);
    end
  endtask

  task automatic t_clean();
    udp4(32, 1000, 53, 12); run(32, 0);
    chk("R8 clean udp", snap, ex(0,1,0,0,0,0,0));
    tcp4(40, 1234, 80, 8'h10); run(40, 0);
    chk("R8 clean tcp", snap, ex(0,1,0,0,0,0,0));
    mk4(5, 1, 20, 64, 0, 0); run(20, 0);
    chk("R8 icmp no l4", snap, ex(0,0,0,0,0,0,0));
  endtask

  task automatic t_version();
    udp4(28, 1, 2, 8); pk[0] = 8'h55; run(28, 0);
    chk("R2 version 5", snap, ex(0,0,0,1,0,0,1));
    clr(); pk[0] = 8'h05; run(1, 0);
    chk("R2 version 0 single byte", snap, ex(0,0,0,1,0,0,1));
  endtask

  task automatic t_csum();
    udp4(28, 1, 2, 8); pk[10] ^= 8'h01; run(28, 0);
    chk("R3 bad checksum", snap, ex(0,1,0,1,0,0,2));
    mk4(5, 17, 28, 0, 0, 0); l4(20, 1, 2, 8, 0); pk[11] ^= 8'h80; run(28, 0);
    chk("R6 csum beats ttl0", snap, ex(0,1,0,1,0,0,2));
  endtask

  task automatic t_short_hdr();
    udp4(28, 1, 2, 8); run(12, 0);
    chk("R4 v4 cut header", snap, ex(0,0,0,1,0,0,3));
    mk6(8, 17, 64); run(30, 0);
    chk("R4 v6 cut header", snap, ex(1,0,0,1,0,0,3));
    mk4(4, 17, 40, 64, 0, 0); run(40, 0);
    chk("R4 ihl below 5", snap, ex(0,0,0,1,0,0,3));
  endtask

  task automatic t_trunc();
    udp4(40, 1, 2, 20); run(30, 0);
    chk("R5 truncated", snap, ex(0,1,0,1,0,0,4));
    udp4(28, 7, 9, 8); run(40, 0);
    chk("R5 pad allowed", snap, ex(0,1,0,0,0,0,0));
  endtask

  task automatic t_ttl_opts();
    mk4(5, 17, 28, 0, 0, 0); l4(20, 1, 2, 8, 0); run(28, 0);
    chk("R6 ttl zero", snap, ex(0,1,0,1,0,0,5));
    mk4(6, 17, 32, 64, 0, 0); l4(24, 1, 2, 8, 0); run(32, 0);
    chk("R6 options", snap, ex(0,1,0,1,0,0,6));
    mk4(6, 17, 32, 0, 0, 0); run(32, 0);
    chk("R6 ttl0 beats options", snap, ex(0,1,0,1,0,0,5));
  endtask

  task automatic t_frag();
    mk4(5, 17, 28, 64, 8'h20, 0); l4(20, 0, 2, 8, 0); run(28, 0);
    chk("R7 more fragments", snap, ex(0,1,1,0,0,0,0));
    mk4(5, 6, 40, 64, 0, 1); l4(20, 1, 2, 0, 0); run(40, 0);
    chk("R7 nonzero offset", snap, ex(0,1,1,0,0,0,0));
    mk6(8, 44, 64); run(48, 0);
    chk("R7 v6 fragment header", snap, ex(1,0,1,0,0,0,0));
  endtask

  task automatic t_l4_short();
    tcp4(30, 1, 2, 8'h10); run(30, 0);
    chk("R9 tcp room 10", snap, ex(0,1,0,0,1,0,1));
    udp4(27, 1, 2, 7); run(27, 0);
    chk("R9 udp room 7", snap, ex(0,1,0,0,1,0,1));
    udp4(28, 1, 2, 8); run(28, 0);
    chk("R9 udp room 8", snap, ex(0,1,0,0,0,0,0));
  endtask

  task automatic t_udp_len();
    udp4(36, 1, 2, 17); run(36, 0);
    chk("R10 ulen over", snap, ex(0,1,0,0,1,0,3));
    udp4(36, 1, 2, 16); run(36, 0);
    chk("R10 ulen exact", snap, ex(0,1,0,0,0,0,0));
    udp4(36, 0, 2, 17); run(36, 0);
    chk("R10 ulen beats port0", snap, ex(0,1,0,0,1,0,3));
  endtask

  task automatic t_port0();
    tcp4(40, 0, 80, 8'h10); run(40, 0);
    chk("R11 tcp sport 0", snap, ex(0,1,0,0,1,0,4));
    udp4(28, 5, 0, 8); run(28, 0);
    chk("R11 udp dport 0", snap, ex(0,1,0,0,1,0,4));
  endtask

  task automatic t_tcp_flags();
    int fl [9] = '{8'h01, 8'h00, 8'h05, 8'h22, 8'h06, 8'h03, 8'h07, 8'h12, 8'h11};
    int cd [9] = '{8, 9, 10, 11, 12, 13, 10, 0, 0};
    for (int k = 0; k < 9; k++) begin
      tcp4(40, 1234, 80, fl[k]); run(40, 0);
      chk($sformatf("R12 flags %02h", fl[k]), snap, ex(0,1,0,0,cd[k] != 0,0,cd[k]));
    end
  endtask

  task automatic t_v6();
    mk6(20, 6, 64); l4(40, 1234, 80, 0, 8'h02); run(60, 0);
    chk("R8 v6 tcp clean", snap, ex(1,1,0,0,0,0,0));
    mk6(8, 17, 0); l4(40, 1, 2, 8, 0); run(48, 0);
    chk("R6 v6 hop zero", snap, ex(1,1,0,1,0,0,5));
    mk6(8, 17, 64); l4(40, 1, 0, 8, 0); run(48, 0);
    chk("R11 v6 udp dport 0", snap, ex(1,1,0,0,1,0,4));
    mk6(20, 17, 64); l4(40, 1, 2, 20, 0); run(50, 0);
    chk("R5 v6 truncated", snap, ex(1,1,0,1,0,0,4));
  endtask

  task automatic t_rx_err();
    udp4(28, 1, 2, 8); pk[0] = 8'h75; run(28, 1);
    chk("R13 rx error masks", snap, ex(0,0,0,0,0,1,0));
    udp4(28, 1, 2, 8); run(28, 1);
    chk("R13 rx error clean pkt", snap, ex(0,0,0,0,0,1,0));
  endtask

  task automatic t_back2back();
    udp4(28, 1, 2, 8); send(28, 0);
    clr(); pk[0] = 8'h95; send(20, 0);
    chk("R1 back-to-back first", snap, ex(0,1,0,0,0,0,0));
    finish_pkt();
    chk("R1 back-to-back second", snap, ex(0,0,0,1,0,0,1));
    @(negedge clk);
    checks++;
    if (st_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 single record actual=%b expected=0", st_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean();
    t_version();
    t_csum();
    t_short_hdr();
    t_trunc();
    t_ttl_opts();
    t_frag();
    t_l4_short();
    t_udp_len();
    t_port0();
    t_tcp_flags();
    t_v6();
    t_rx_err();
    t_back2back();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule